// File: doc/BRIEF.md
# Memory-Side Atomic Read-Modify-Write Unit

This unit sits beside a small word-addressed storage array, such as a shared cache bank or a register file of a peripheral, and performs atomic read-modify-write updates where the data lives. A requester sends one request that carries a word address, an opcode and an operand. The unit reads the stored word, combines it with the operand, writes the result back, and returns one response word. That word is the value the location held before the update. The requester never fetches the word and never writes it back itself. The whole exchange takes about as long as a plain read.

Requests and responses each use a valid/ready handshake. The unit accepts only one request at a time. The next request is not taken until the current update has been written and its response has been handed over. Any sequence of requests therefore behaves as if each one ran alone. A request whose address lies outside the array, or whose opcode is not defined, comes back with an error flag and leaves the storage unchanged.

Top module: `amo_exec`

## Requirements
- R1: After reset, reqReady is 1, rspValid is 0, and every storage word reads as zero.
- R2: Opcode 0 adds the operand to the stored word modulo 2^DATA_W. Every accepted, error-free request returns the word as it was before the update.
- R3: Opcodes 1, 2 and 3 store the bitwise AND, OR and XOR, in that order, of the stored word and the operand.
- R4: Opcode 4 stores the operand unchanged and returns the previous word.
- R5: Opcodes 5 and 6 store the signed two's-complement minimum and maximum, in that order, of the stored word and the operand.
- R6: Opcodes 7 and 8 store the unsigned minimum and maximum, in that order, of the stored word and the operand.
- R7: A request whose address is DEPTH or more returns rspErr = 1 and rspData = 0. It changes no storage word, including the word its low address bits would alias.
- R8: A request with an opcode from 9 to 15 returns rspErr = 1 and rspData = 0, and it changes no storage word.
- R9: reqReady is low from the edge that accepts a request until the edge that completes its response handshake. A request offered in that window is not taken. rspValid rises on the second rising edge counted from the accepting edge, that edge included.
- R10: While rspValid is 1 and rspReady is 0, rspValid stays 1 and rspData and rspErr hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Unit can take a request |
| reqAddr | input | ADDR_W | Word address |
| reqOp | input | 4 | Operation code |
| reqData | input | DATA_W | Operand |
| rspValid | output | 1 | Response available |
| rspReady | input | 1 | Requester takes the response |
| rspData | output | DATA_W | Word value before the update, zero on error |
| rspErr | output | 1 | Bad address or undefined opcode |

## Verification
The hardest case to reach from the ports is a second request that arrives while an earlier one is still in flight. In that case the held response must not change, and the late request must leave no trace in storage. The stimulus holds rspReady low for several cycles after a response appears and offers a swap request during that window. It then reads the targeted word back with an OR of zero, which shows that the swap was never taken. An out-of-range address whose low bits alias word 0 is followed by a read of word 0, which exposes a missing range check.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_AND  = 4'd1,
    OP_OR   = 4'd2,
    OP_XOR  = 4'd3,
    OP_SWAP = 4'd4,
    OP_MIN  = 4'd5,
    OP_MAX  = 4'd6,
    OP_MINU = 4'd7,
    OP_MAXU = 4'd8
  } amoOp_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_RESP = 2'd2
  } ctrlState_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic latchReq;  // capture the request fields this cycle
    logic commit;    // write the result back and load the response
  } ctrlStrobe_t;

endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] oldVal,
  input  logic [DATA_W-1:0] operand,
  input  logic [3:0]        opCode,
  output logic [DATA_W-1:0] newVal,
  output logic              opValid
);

  logic signedLess;
  logic unsignedLess;

  assign signedLess   = $signed(operand) < $signed(oldVal);
  assign unsignedLess = operand < oldVal;

  always_comb begin
    newVal  = oldVal;
    opValid = 1'b1;
    case (opCode)
      OP_ADD:  newVal = oldVal + operand;
      OP_AND:  newVal = oldVal & operand;
      OP_OR:   newVal = oldVal | operand;
      OP_XOR:  newVal = oldVal ^ operand;
      OP_SWAP: newVal = operand;
      OP_MIN:  newVal = signedLess   ? operand : oldVal;
      OP_MAX:  newVal = signedLess   ? oldVal  : operand;
      OP_MINU: newVal = unsignedLess ? operand : oldVal;
      OP_MAXU: newVal = unsignedLess ? oldVal  : operand;
      default: opValid = 1'b0;
    endcase
  end

endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        rspValid,
  input  logic        rspReady,
  output ctrlStrobe_t strobe
);

  ctrlState_e stateQ;
  ctrlState_e stateD;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (reqValid) stateD = ST_EXEC;
      ST_EXEC: stateD = ST_RESP;
      ST_RESP: if (rspReady) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

  assign reqReady        = (stateQ == ST_IDLE);
  assign rspValid        = (stateQ == ST_RESP);
  assign strobe.latchReq = reqValid && reqReady;
  assign strobe.commit   = (stateQ == ST_EXEC);

  // R9: once a request is captured, no further request is taken.
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.latchReq |=> !reqReady);

  // R9: the commit step is followed directly by a visible response.
  p_rsp_after_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.commit |=> rspValid && !reqReady);

endmodule

// File: rtl/amo_datapath.sv
module amo_datapath
  import amo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqOp,
  input  logic [DATA_W-1:0] reqData,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

  logic [ADDR_W-1:0] addrQ;
  logic [3:0]        opQ;
  logic [DATA_W-1:0] operandQ;
  logic [DATA_W-1:0] rspDataQ;
  logic              rspErrQ;

  logic [DEPTH-1:0][DATA_W-1:0] memRd;
  logic [IDX_W-1:0]  wordIdx;
  logic              inRange;
  logic [DATA_W-1:0] oldVal;
  logic [DATA_W-1:0] newVal;
  logic              opValid;
  logic              reqErr;

  // Request capture.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ    <= '0;
      opQ      <= '0;
      operandQ <= '0;
    end else if (strobe.latchReq) begin
      addrQ    <= reqAddr;
      opQ      <= reqOp;
      operandQ <= reqData;
    end
  end

  assign inRange = {1'b0, addrQ} < LIMIT;
  assign wordIdx = addrQ[IDX_W-1:0];
  assign oldVal  = inRange ? memRd[wordIdx] : '0;
  assign reqErr  = !inRange || !opValid;

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .oldVal  (oldVal),
    .operand (operandQ),
    .opCode  (opQ),
    .newVal  (newVal),
    .opValid (opValid)
  );

  // Storage words, one register each.
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DATA_W-1:0] wordQ;
    logic              wrEn;
    assign wrEn = strobe.commit && !reqErr && inRange && (wordIdx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    wordQ <= '0;
      else if (wrEn) wordQ <= newVal;
    end
    assign memRd[g] = wordQ;
  end

  // Response register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspDataQ <= '0;
      rspErrQ  <= 1'b0;
    end else if (strobe.commit) begin
      rspDataQ <= reqErr ? '0 : oldVal;
      rspErrQ  <= reqErr;
    end
  end

  assign rspData = rspDataQ;
  assign rspErr  = rspErrQ;

  // R7 and R8: a rejected request leaves every word untouched.
  p_err_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.commit && reqErr |=> $stable(memRd));

  // R9: storage changes only in the commit step.
  p_write_only_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.commit |=> $stable(memRd));

  // R4: a swap leaves exactly the operand in the addressed word.
  p_swap_stores_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.commit && !reqErr && (opQ == OP_SWAP) |=> memRd[$past(wordIdx)] == $past(operandQ));

endmodule

// File: rtl/amo_exec.sv
module amo_exec
  import amo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqOp,
  input  logic [DATA_W-1:0] reqData,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr
);

  ctrlStrobe_t strobe;

  amo_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .rspReady (rspReady),
    .strobe   (strobe)
  );

  amo_datapath #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqOp   (reqOp),
    .reqData (reqData),
    .rspData (rspData),
    .rspErr  (rspErr)
  );

  // R10: a stalled response holds its value.
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid && !rspReady |=> rspValid && $stable(rspData) && $stable(rspErr));

  // R9: request and response sides are never open together.
  p_one_in_flight_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> !reqReady);

endmodule

// File: tb/amo_exec_bench.sv
module amo_exec_bench;

  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [3:0]        reqOp = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic              rspValid;
  logic              rspReady = 1'b0;
  logic [DATA_W-1:0] rspData;
  logic              rspErr;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  amo_exec #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_amo_exec (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .reqAddr  (reqAddr),
    .reqOp    (reqOp),
    .reqData  (reqData),
    .rspValid (rspValid),
    .rspReady (rspReady),
    .rspData  (rspData),
    .rspErr   (rspErr)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [7:0]  addr;
    logic [31:0] arg;
    logic [31:0] expRsp;
    logic        expErr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 8'd0,   32'h0,        32'h0,        1'b0, 4'd1},  // R1 word 0 is zero
    '{4'd0, 8'd1,   32'h5,        32'h0,        1'b0, 4'd2},  // R2 add
    '{4'd0, 8'd1,   32'hFFFFFFFF, 32'h5,        1'b0, 4'd2},  // R2 add wraps to 4
    '{4'd2, 8'd1,   32'h0,        32'h4,        1'b0, 4'd2},  // R2 wrapped value
    '{4'd4, 8'd2,   32'hF0F0F0F0, 32'h0,        1'b0, 4'd4},  // R4 swap
    '{4'd1, 8'd2,   32'hFF00FF00, 32'hF0F0F0F0, 1'b0, 4'd3},  // R3 and
    '{4'd2, 8'd2,   32'h0000000F, 32'hF000F000, 1'b0, 4'd3},  // R3 or
    '{4'd3, 8'd2,   32'hFFFFFFFF, 32'hF000F00F, 1'b0, 4'd3},  // R3 xor
    '{4'd2, 8'd2,   32'h0,        32'h0FFF0FF0, 1'b0, 4'd3},  // R3 result
    '{4'd4, 8'd3,   32'hFFFFFFFE, 32'h0,        1'b0, 4'd4},  // R4 swap -2
    '{4'd5, 8'd3,   32'h3,        32'hFFFFFFFE, 1'b0, 4'd5},  // R5 min keeps -2
    '{4'd6, 8'd3,   32'h3,        32'hFFFFFFFE, 1'b0, 4'd5},  // R5 max gives 3
    '{4'd5, 8'd3,   32'hFFFFFFF0, 32'h3,        1'b0, 4'd5},  // R5 min gives -16
    '{4'd7, 8'd3,   32'h3,        32'hFFFFFFF0, 1'b0, 4'd6},  // R6 minu gives 3
    '{4'd8, 8'd3,   32'h80000000, 32'h3,        1'b0, 4'd6},  // R6 maxu
    '{4'd6, 8'd3,   32'h1,        32'h80000000, 1'b0, 4'd5},  // R5 max gives 1
    '{4'd8, 8'd3,   32'h0,        32'h1,        1'b0, 4'd6},  // R6 maxu keeps 1
    '{4'd2, 8'd3,   32'h0,        32'h1,        1'b0, 4'd6},  // R6 result
    '{4'd0, 8'd16,  32'h7,        32'h0,        1'b1, 4'd7},  // R7 first bad address
    '{4'd4, 8'd255, 32'h1,        32'h0,        1'b1, 4'd7},  // R7 top address
    '{4'd9, 8'd1,   32'h1,        32'h0,        1'b1, 4'd8},  // R8 opcode 9
    '{4'd15,8'd1,   32'h1,        32'h0,        1'b1, 4'd8},  // R8 opcode 15
    '{4'd2, 8'd1,   32'h0,        32'h4,        1'b0, 4'd8},  // R8 word 1 untouched
    '{4'd2, 8'd15,  32'h0,        32'h0,        1'b0, 4'd1},  // R1 last word zero
    '{4'd4, 8'd15,  32'hABCD0123, 32'h0,        1'b0, 4'd4},  // R4 last word
    '{4'd2, 8'd15,  32'h0,        32'hABCD0123, 1'b0, 4'd4},  // R4 result
    '{4'd2, 8'd0,   32'h0,        32'h0,        1'b0, 4'd7}   // R7 alias word 0 untouched
  };

  task automatic chk(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReq(input logic [3:0] op, input logic [7:0] addr, input logic [31:0] arg,
                       output logic [31:0] rsp, output logic err, output int lat);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = addr; reqData = arg;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 0;
    while (!rspValid) begin @(negedge clk); lat++; end
    rsp = rspData; err = rspErr;
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rsp;
    logic        err;
    int          lat;
    logic [31:0] held;

    repeat (3) @(negedge clk);
    // R1: reset state at the ports.
    chk(reqReady == 1'b1, 1, 32'(reqReady), 32'd1);
    chk(rspValid == 1'b0, 1, 32'(rspValid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1 && rspValid == 1'b0, 1, {30'd0, reqReady, rspValid}, 32'd2);

    for (int i = 0; i < NV; i++) begin
      doReq(VECS[i].op, VECS[i].addr, VECS[i].arg, rsp, err, lat);
      chk(rsp == VECS[i].expRsp, int'(VECS[i].req), rsp, VECS[i].expRsp);
      chk(err == VECS[i].expErr, int'(VECS[i].req), 32'(err), 32'(VECS[i].expErr));
      chk(lat == 1, 9, 32'(lat), 32'd1);  // R9 response timing
    end

    // R10 and R9: stall the response and offer a second request meanwhile.
    @(negedge clk);
    reqValid = 1'b1; reqOp = 4'd0; reqAddr = 8'd5; reqData = 32'd9;
    @(posedge clk);
    @(negedge clk);
    reqOp = 4'd4; reqData = 32'd777;  // stray swap kept on offer
    chk(reqReady == 1'b0, 9, 32'(reqReady), 32'd0);
    @(negedge clk);
    held = rspData;
    chk(rspValid == 1'b1 && held == 32'd0, 10, held, 32'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(rspValid == 1'b1 && rspData == held && rspErr == 1'b0, 10, rspData, held);
      chk(reqReady == 1'b0, 9, 32'(reqReady), 32'd0);
    end
    reqValid = 1'b0;
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    chk(reqReady == 1'b1 && rspValid == 1'b0, 9, {30'd0, reqReady, rspValid}, 32'd2);
    doReq(4'd2, 8'd5, 32'd0, rsp, err, lat);
    chk(rsp == 32'd9 && !err, 9, rsp, 32'd9);  // R9 stray swap not taken

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule